// File: doc/BRIEF.md
# Store-and-Forward Packet Transmit Buffer

This block sits between a user packet source and a link core that pulls packet words at its own pace. The source pushes 128-bit words, each tagged with start and end markers, through a valid/ready handshake. The buffer stores them and shows the source an early-warning flag when space is nearly used up.

A packet becomes visible on the core side only after its last word is stored. From then on, the core's per-cycle enable alone sets the transfer rate. The buffer never leaves a hole inside a packet, and it keeps the head word, start marker and end marker steady until the core takes that word. A count of complete packets held in storage decides when the output side has something to offer.

Top module: `pkt_tx_buffer`

## Requirements
- R1: A synchronous active-low reset empties the buffer. After it, `in_ready` is 1, `in_almost_full` is 0, and `out_sop` and `out_eop` are 0.
- R2: Words of a packet whose end word has not yet been stored are not offered. `out_sop` and `out_eop` stay 0 while no complete packet is held.
- R3: An offered packet appears in write order, with `out_sop` = 1 only on its first word and `out_data` equal to the stored word.
- R4: While a word is offered and `out_en` is 0, `out_data`, `out_sop` and `out_eop` keep their values on the next cycle.
- R5: Once a packet has started, every cycle with `out_en` = 1 takes one word, and the next word is offered on the following cycle with no gap. `out_eop` = 1 marks the last word.
- R6: `out_en` = 1 while nothing is offered has no effect: no word is dropped or skipped.
- R7: `in_almost_full` is 1 exactly when fewer than `AF_FREE` (default 8) entries are free. With the default depth of 64, this means 57 or more words are stored.
- R8: `in_ready` is 0 when all `DEPTH` entries hold words. A word presented with `in_valid` = 1 while `in_ready` = 0 is not stored.
- R9: Several complete packets stored back to back are offered in order. Storing an end word on the same cycle that an end word is taken leaves the number of offered packets unchanged.
- R10: A one-word packet is offered with `out_sop` and `out_eop` both 1 on the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_ready | output | 1 | Buffer can take a word this cycle |
| in_almost_full | output | 1 | Fewer than `AF_FREE` entries are free |
| in_sop | input | 1 | Word is the first of its packet |
| in_eop | input | 1 | Word is the last of its packet |
| in_data | input | DATA_W | Packet word from the source |
| out_en | input | 1 | Core takes the offered word this cycle |
| out_sop | output | 1 | Offered word is the first of its packet |
| out_eop | output | 1 | Offered word is the last of its packet |
| out_data | output | DATA_W | Offered packet word |

## Verification
The bench targets the cases where a careless buffer leaks or loses words:
- A partial packet with the core enable held high. A design that keyed the output on occupancy would start the packet early.
- An end word written in the same cycle that an end word is taken. A mishandled packet counter would hide or duplicate the next packet.
- A fill to exactly full, followed by a word pushed against a deasserted ready. This catches an off-by-one almost-full threshold and a write into a full buffer.
- A full-depth packet drained at the core's fastest rate, and enable pulses while idle. These expose pointer wrap faults and pointer advances with nothing offered.

// File: rtl/ptb_pkg.sv
// Package: shared types for the packet transmit buffer.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package ptb_pkg;

    // Per-word packet markers kept alongside each stored data word.
    typedef struct packed {
        logic sop;
        logic eop;
    } ptb_flags_t;

endpackage

// File: rtl/ptb_store.sv
// Module: circular word storage with read/write pointers and occupancy.
// Assumes: the caller never writes when full nor reads when empty;
// head outputs change only after a read or a write into an empty store.
module ptb_store
    import ptb_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  ptb_flags_t                    wr_flags,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rd_en,
    output ptb_flags_t                    head_flags,
    output logic [DATA_W-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]    used,
    output logic                          full,
    output logic                          empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DATA_W-1:0] data_mem  [DEPTH];
    ptb_flags_t        flag_mem  [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    // Step a pointer by one, wrapping at the last entry.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Store the incoming word and its markers at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_ptr] <= wr_data;
            flag_mem[wr_ptr] <= wr_flags;
        end
    end

    // Advance both pointers on their enables; reset empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= step(wr_ptr);
            if (rd_en) rd_ptr <= step(rd_ptr);
        end
    end

    // Track how many entries are occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else begin
            case ({wr_en, rd_en})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    // Expose the head entry and the full/empty conditions.
    always_comb begin
        head_data  = data_mem[rd_ptr];
        head_flags = flag_mem[rd_ptr];
        full       = (used == CAP);
        empty      = (used == '0);
    end

    // R8: the caller must gate writes with the full condition.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R6: reads only happen while a word is held.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/ptb_pkt_count.sv
// Module: counts packets whose last word is stored but not yet taken.
// Assumes: a taken end word always belongs to a counted packet.
module ptb_pkt_count #(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eop_in,
    input  logic                        eop_out,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        avail
);
    // Up on each stored end word, down on each taken end word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({eop_in, eop_out})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // A complete packet is ready whenever the count is non-zero.
    always_comb avail = (count != '0);

    // R9: an end word is only taken from a counted packet.
    assert_count_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eop_out |-> avail);

endmodule

// File: rtl/pkt_tx_buffer.sv
// Module: store-and-forward transmit buffer between a packet source and
// a link core. A packet is offered only when complete; the core's enable
// then paces it without gaps. Assumes no packet exceeds DEPTH words.
module pkt_tx_buffer
    import ptb_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int DEPTH   = 64,
    parameter int AF_FREE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              in_almost_full,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_en,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] AF_LIMIT = CW'(DEPTH - AF_FREE);

    logic              accept;
    logic              consume;
    logic              present;
    ptb_flags_t        wr_flags;
    ptb_flags_t        head_flags;
    logic [DATA_W-1:0] head_data;
    logic [CW-1:0]     used;
    logic [CW-1:0]     pkt_cnt;
    logic              full;
    logic              empty;

    // Source-side handshake, markers and space warning.
    always_comb begin
        in_ready       = !full;
        accept         = in_valid && in_ready;
        wr_flags.sop   = in_sop;
        wr_flags.eop   = in_eop;
        in_almost_full = (used > AF_LIMIT);
    end

    // Core-side view: offer the head word only if a full packet is held.
    always_comb begin
        consume  = present && out_en;
        out_sop  = present && head_flags.sop;
        out_eop  = present && head_flags.eop;
        out_data = head_data;
    end

    ptb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept),
        .wr_flags   (wr_flags),
        .wr_data    (in_data),
        .rd_en      (consume),
        .head_flags (head_flags),
        .head_data  (head_data),
        .used       (used),
        .full       (full),
        .empty      (empty)
    );

    ptb_pkt_count #(.DEPTH(DEPTH)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .eop_in  (accept && in_eop),
        .eop_out (consume && head_flags.eop),
        .count   (pkt_cnt),
        .avail   (present)
    );

    // R1: reset leaves nothing offered and the source side open.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_sop && !out_eop && in_ready && !in_almost_full));
    // R4: an untaken word holds steady.
    assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (present && !out_en) |=> (present && $stable(out_data)
                                  && $stable(out_sop) && $stable(out_eop)));
    // R5: taking a non-final word leaves the rest of the packet on offer.
    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (present && out_en && !out_eop) |=> (present && !out_sop));
    // R2: complete packets never outnumber stored words.
    assert_pkt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt <= used) && (present -> !empty));
    // R7: the warning is up whenever the buffer is full.
    assert_af_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> in_almost_full);

endmodule

// File: tb/pkt_tx_buffer_test.sv
module pkt_tx_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 128;
    localparam int DEP  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_en = 1'b0;
    logic          in_ready, in_almost_full, out_sop, out_eop;
    logic [DW-1:0] out_data;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;

    pkt_tx_buffer #(.DATA_W(DW), .DEPTH(DEP), .AF_FREE(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_almost_full(in_almost_full), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .out_en(out_en), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       v, s, e;
        logic [7:0] tag;
        logic       en;
        logic       xp, xs, xe;
        logic [7:0] xt;
        logic [3:0] req;
    } row_t;

    // Per cycle: write inputs, enable, and expected outputs before the edge.
    localparam row_t TBL [19] = '{
        '{1,1,0,8'h11,1, 0,0,0,8'h00, 4'd6},  // R6 enable while idle
        '{1,0,0,8'h12,1, 0,0,0,8'h00, 4'd2},  // R2 partial hidden
        '{1,0,1,8'h13,0, 0,0,0,8'h00, 4'd2},
        '{0,0,0,8'h00,0, 1,1,0,8'h11, 4'd3},  // R3 first word offered
        '{0,0,0,8'h00,0, 1,1,0,8'h11, 4'd4},  // R4 held
        '{0,0,0,8'h00,1, 1,1,0,8'h11, 4'd3},
        '{0,0,0,8'h00,0, 1,0,0,8'h12, 4'd4},
        '{0,0,0,8'h00,1, 1,0,0,8'h12, 4'd5},  // R5 no gap
        '{0,0,0,8'h00,1, 1,0,1,8'h13, 4'd5},
        '{1,1,1,8'h21,1, 0,0,0,8'h00, 4'd6},
        '{1,1,0,8'h31,1, 1,1,1,8'h21, 4'd10}, // R10 single word
        '{1,0,1,8'h32,1, 0,0,0,8'h00, 4'd2},
        '{1,1,1,8'h41,0, 1,1,0,8'h31, 4'd9},  // R9 order
        '{0,0,0,8'h00,1, 1,1,0,8'h31, 4'd9},
        '{0,0,0,8'h00,1, 1,0,1,8'h32, 4'd5},
        '{0,0,0,8'h00,0, 1,1,1,8'h41, 4'd9},
        '{1,1,1,8'h51,1, 1,1,1,8'h41, 4'd9},  // R9 write/take end together
        '{0,0,0,8'h00,1, 1,1,1,8'h51, 4'd9},
        '{0,0,0,8'h00,0, 0,0,0,8'h00, 4'd6}
    };

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(in_ready === 1'b1, "R1 ready", DW'(in_ready), 1);
        check(in_almost_full === 1'b0, "R1 almost_full", DW'(in_almost_full), 0);
        check({out_sop, out_eop} === 2'b00, "R1 markers", DW'({out_sop, out_eop}), 0);

        for (int i = 0; i < 19; i++) begin
            string rq;
            rq = $sformatf("R%0d row %0d", TBL[i].req, i);
            check(in_ready === 1'b1, rq, DW'(in_ready), 1);
            check(out_sop === TBL[i].xs, rq, DW'(out_sop), DW'(TBL[i].xs));
            check(out_eop === TBL[i].xe, rq, DW'(out_eop), DW'(TBL[i].xe));
            if (TBL[i].xp)
                check(out_data === {16{TBL[i].xt}}, rq, out_data, {16{TBL[i].xt}});
            in_valid = TBL[i].v;
            in_sop   = TBL[i].s;
            in_eop   = TBL[i].e;
            in_data  = {16{TBL[i].tag}};
            out_en   = TBL[i].en;
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_en   = 1'b0;

        // R7 / R8: fill with a packet that never ends
        for (int i = 0; i < DEP; i++) begin
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = 1'b0;
            in_data  = {16{8'(i)}};
            @(negedge clk);
            if (i + 1 == 56)
                check(in_almost_full === 1'b0, "R7 at 56 words", DW'(in_almost_full), 0);
            if (i + 1 == 57)
                check(in_almost_full === 1'b1, "R7 at 57 words", DW'(in_almost_full), 1);
        end
        check(in_ready === 1'b0, "R8 full", DW'(in_ready), 0);
        in_eop  = 1'b1;
        in_data = {16{8'hEE}};
        @(negedge clk);
        // R8: the end word pushed against a full buffer must not land
        check(out_sop === 1'b0, "R8 ignored write", DW'(out_sop), 0);
        check(in_ready === 1'b0, "R8 still full", DW'(in_ready), 0);
        in_valid = 1'b0;
        in_eop   = 1'b0;

        // R1: reset from a full state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(in_ready === 1'b1 && in_almost_full === 1'b0, "R1 after refill reset",
              DW'({in_ready, in_almost_full}), 2);
        check(out_sop === 1'b0, "R1 sop cleared", DW'(out_sop), 0);

        // R5: full-depth packet drained at the fastest rate
        for (int i = 0; i < DEP; i++) begin
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = (i == DEP - 1);
            in_data  = {16{8'(i + 8'h80)}};
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
        out_en   = 1'b1;
        for (int i = 0; i < DEP; i++) begin
            check(out_data === {16{8'(i + 8'h80)}}, "R5 long data", out_data,
                  {16{8'(i + 8'h80)}});
            check(out_sop === (i == 0) && out_eop === (i == DEP - 1), "R5 long markers",
                  DW'({out_sop, out_eop}), DW'({i == 0, i == DEP - 1}));
            @(negedge clk);
        end
        out_en = 1'b0;
        check({out_sop, out_eop} === 2'b00, "R6 drained", DW'({out_sop, out_eop}), 0);
        finish_run();
    end
endmodule